// File: doc/BRIEF.md
# Metering pulse spacer and shaper

This block sits between a measurement engine and two energy pulse pins, one for real power and one for reactive power. The engine raises single-cycle request strobes. When a nonzero interval is programmed, each channel counts its requests in a small queue and lets them out one at a time, four interval units apart. This spreads a burst of requests evenly across an integration frame. For example, six requests per frame of 1950 filter-clock cycles suit an interval of 81. When the interval is zero, the queue is bypassed and every request acts at once.

Every request that leaves a channel toggles that channel's active state. With no width cap, a pulse therefore stays active until the next request and gives a 50% duty waveform at the request rate. With a cap (nonzero interval and a maximum-width value other than 255), an active phase also ends after (2 × maxwidth + 1) × interval ticks. Pins idle high and are active low, and one invert control flips both pins. All timing counts advance only on cycles where the filter-clock enable input is high, and the whole block runs on a single system clock.

Top module: `pulse_spacer`

## Requirements
- R1: After reset both pins are at the idle level (high while `invert_i`=0), `ovf_o` is 0 and both queues are empty.
- R2: Each pin shows its channel's active state: low when active and `invert_i`=0, high when active and `invert_i`=1. A change of `invert_i` acts on both pins in the same cycle.
- R3: With `interval_i`=0, a request in cycle k toggles that channel's active state, visible after the edge that ends cycle k, whatever `tick_i` is. The queue is held empty in this mode.
- R4: With `interval_i`≠0, a request is counted into its channel's queue. A queued request leaves on the first clock edge with `tick_i`=1 that follows its arrival edge, once the spacing since the previous release has elapsed.
- R5: Two successive releases on one channel are exactly 4 × `interval_i` ticks apart.
- R6: With `max_width_i`=255, each release toggles the active state, so an active phase lasts until the next release (50% duty).
- R7: With `interval_i`≠0 and `max_width_i`≠255, a release from idle starts an active phase. The phase returns to idle after (2 × `max_width_i` + 1) × `interval_i` ticks, or earlier if another release toggles it.
- R8: Each queue holds 8 requests. A request that arrives at a full queue with no release in the same cycle is dropped and sets that channel's sticky `ovf_o` bit. `ovf_clr_i` clears the bit on the next edge. A set in the same cycle wins over the clear.
- R9: Bit 0 of `req_i`, `pulse_o` and `ovf_o` is the real-power channel and bit 1 is the reactive-power channel. The two channels never affect each other.
- R10: The spacing and width counts advance only on edges with `tick_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Filter-clock enable; timing counts advance when high |
| req_i | input | 2 | Pulse request strobes, bit 0 real, bit 1 reactive |
| interval_i | input | 8 | Spacing unit; 0 selects bypass |
| max_width_i | input | 8 | Width cap setting; 255 disables the cap |
| invert_i | input | 1 | 1 makes both pins active high |
| ovf_clr_i | input | 1 | Clears both sticky overflow bits |
| pulse_o | output | 2 | Pulse pins |
| ovf_o | output | 2 | Sticky overflow per channel |

## Verification
A request changes a pin one edge later in bypass mode. In queue mode the change comes on the first ticked edge after the arrival edge. The phase then closes exactly 4 × interval ticks later in toggle mode, or (2 × maxwidth + 1) × interval ticks later under a cap. The invert control acts within the same cycle. Directed cases count how many falling-edge samples a pin spends active and compare that count with those tick products. With ticks on every other cycle, the same width spans exactly twice as many clock cycles. In the random segments a bench model is advanced at each rising edge from the inputs held there, and both pins and overflow bits are compared at the following falling edge. Overflow is read one edge after the ninth unreleased request, and again one edge after the clear strobe.

// File: rtl/pulse_spacer_pkg.sv
package pulse_spacer_pkg;
  parameter int unsigned NCH      = 2;
  parameter int unsigned IV_W     = 8;
  parameter int unsigned MW_W     = 8;
  parameter int unsigned Q_DEPTH  = 8;
  parameter int unsigned SP_W     = IV_W + 2;
  parameter int unsigned SPAN_W   = MW_W + 1 + IV_W;
  parameter int unsigned CNT_W    = $clog2(Q_DEPTH + 1);
endpackage

// File: rtl/pulse_queue.sv
module pulse_queue
  import pulse_spacer_pkg::*;
#(
  parameter int unsigned DEPTH = Q_DEPTH,
  parameter int unsigned IW    = IV_W,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned SW   = IW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          req_i,
  input  logic [IW-1:0] interval_i,
  input  logic          ovf_clr_i,
  output logic          rel_o,
  output logic          ovf_o
);
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] sp_q;
  logic          bypass, full, push;

  assign bypass = (interval_i == '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign rel_o  = bypass ? req_i : (tick_i && cnt_q != '0 && sp_q == '0);
  assign push   = req_i && (!full || rel_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sp_q  <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (bypass) begin
        cnt_q <= '0;
        sp_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(push) - CW'(rel_o);
        if (rel_o)                     sp_q <= {interval_i, 2'b00} - SW'(1);
        else if (tick_i && sp_q != '0) sp_q <= sp_q - SW'(1);
      end
      if (!bypass && req_i && full && !rel_o) ovf_o <= 1'b1;
      else if (ovf_clr_i)                     ovf_o <= 1'b0;
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass && req_i && full && !rel_o) |=> (ovf_o && cnt_q == CW'(DEPTH)));
  p_bypass_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |=> cnt_q == '0);
  p_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_o && !bypass) |=> !rel_o);
  p_tick_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !bypass) |=> $stable(sp_q));
endmodule

// File: rtl/pulse_shaper.sv
module pulse_shaper
  import pulse_spacer_pkg::*;
#(
  parameter int unsigned WW = SPAN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rel_i,
  input  logic          cap_en_i,
  input  logic [WW-1:0] span_i,
  output logic          active_o
);
  logic [WW-1:0] wt_q;
  logic          expire;

  assign expire = cap_en_i && active_o && tick_i && wt_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      wt_q     <= '0;
    end else begin
      if (rel_i)       active_o <= !active_o;
      else if (expire) active_o <= 1'b0;
      if (rel_i && !active_o)        wt_q <= cap_en_i ? span_i - WW'(1) : '0;
      else if (tick_i && wt_q != '0) wt_q <= wt_q - WW'(1);
    end
  end

  p_cap_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !rel_i) |=> !active_o);
  p_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |=> active_o != $past(active_o));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !rel_i) |=> $stable(active_o));
endmodule

// File: rtl/pulse_spacer.sv
module pulse_spacer
  import pulse_spacer_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [NCH-1:0]  req_i,
  input  logic [IV_W-1:0] interval_i,
  input  logic [MW_W-1:0] max_width_i,
  input  logic            invert_i,
  input  logic            ovf_clr_i,
  output logic [NCH-1:0]  pulse_o,
  output logic [NCH-1:0]  ovf_o
);
  logic              cap_en;
  logic [SPAN_W-1:0] span;
  logic [NCH-1:0]    rel, active;

  assign cap_en = (interval_i != '0) && (max_width_i != '1);
  assign span   = SPAN_W'({max_width_i, 1'b1}) * SPAN_W'(interval_i);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pulse_queue #(.DEPTH(Q_DEPTH), .IW(IV_W)) u_q (
      .clk_i, .rst_ni, .tick_i,
      .req_i(req_i[c]), .interval_i, .ovf_clr_i,
      .rel_o(rel[c]), .ovf_o(ovf_o[c])
    );
    pulse_shaper #(.WW(SPAN_W)) u_s (
      .clk_i, .rst_ni, .tick_i,
      .rel_i(rel[c]), .cap_en_i(cap_en), .span_i(span),
      .active_o(active[c])
    );
    assign pulse_o[c] = invert_i ? active[c] : !active[c];
  end

  p_bypass_now_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interval_i == '0 && req_i[0]) |=> active[0] != $past(active[0]));
endmodule

// File: tb/sim_pulse_spacer.sv
`timescale 1ns/1ps
module sim_pulse_spacer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] req = '0;
  logic [7:0] iv = '0;
  logic [7:0] mw = 8'hFF;
  logic       inv = 1'b0;
  logic       clr = 1'b0;
  logic [1:0] pulse, ovf;

  int checks = 0, failures = 0;
  int tick_mode = 0;
  bit done = 0;

  // model state
  int m_cnt[2], m_sp[2], m_wt[2];
  bit m_act[2], m_ovf[2];

  always #10 clk = ~clk;

  pulse_spacer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req),
    .interval_i(iv), .max_width_i(mw), .invert_i(inv), .ovf_clr_i(clr),
    .pulse_o(pulse), .ovf_o(ovf)
  );

  always @(negedge clk) begin
    if (tick_mode == 0)      tick <= 1'b1;
    else if (tick_mode == 1) tick <= !tick;
    else                     tick <= ($urandom % 3) != 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_sp[c] = 0; m_wt[c] = 0; m_act[c] = 0; m_ovf[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit byp, full, rel, capen;
        int span;
        byp   = (iv == 0);
        full  = (m_cnt[c] == 8);
        rel   = byp ? req[c] : (tick && m_cnt[c] != 0 && m_sp[c] == 0);
        capen = (iv != 0) && (mw != 255);
        span  = (2 * int'(mw) + 1) * int'(iv);
        if (!byp && req[c] && full && !rel) m_ovf[c] = 1;
        else if (clr) m_ovf[c] = 0;
        if (byp) begin
          m_cnt[c] = 0; m_sp[c] = 0;
        end else begin
          m_cnt[c] = m_cnt[c] + ((req[c] && (!full || rel)) ? 1 : 0) - (rel ? 1 : 0);
          if (rel) m_sp[c] = 4 * int'(iv) - 1;
          else if (tick && m_sp[c] > 0) m_sp[c] = m_sp[c] - 1;
        end
        if (rel && !m_act[c]) m_wt[c] = capen ? span - 1 : 0;
        else if (tick && m_wt[c] > 0) m_wt[c] = m_wt[c] - 1;
        if (rel) m_act[c] = !m_act[c];
        else if (capen && m_act[c] && tick && ((m_wt[c] == 0) || (m_wt[c] == 0))) m_act[c] = m_act[c];
      end
    end
  end

  // width expiry handled in a second pass using pre-edge width state
  int pre_wt[2]; bit pre_act[2]; bit pre_rel_ok[2];
  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      pre_wt[c]  = m_wt[c];
      pre_act[c] = m_act[c];
    end
  end
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        bit capen;
        capen = (iv != 0) && (mw != 255);
        if (capen && pre_act[c] && m_act[c] && tick_at_edge && pre_wt[c] == 0)
          m_act[c] = 0;
      end
    end
  end
  bit tick_at_edge;
  always @(posedge clk) tick_at_edge = tick;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic count_low(input int ch, input int nreq, input int win, output int lowcnt);
    lowcnt = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pulse[ch] == 1'b0) lowcnt++;
      req = (i < nreq) ? (2'b01 << ch) : 2'b00;
    end
    @(negedge clk);
    req = '0;
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    // R1 reset state
    #5;
    chk("R1 pulse in reset", pulse, 2'b11);
    chk("R1 ovf in reset", ovf, 2'b00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R3/R2 bypass and polarity
    @(negedge clk);
    iv = 0; req = 2'b01;
    @(negedge clk);
    req = 2'b00;
    chk("R3 bypass toggles ch0", pulse, 2'b10);
    inv = 1'b1; #1;
    chk("R2 inverted polarity", pulse, 2'b01);
    @(negedge clk);
    req = 2'b10;
    @(negedge clk);
    req = 2'b00;
    chk("R9 R2 ch1 active high", pulse, 2'b11);
    inv = 1'b0; #1;
    chk("R2 normal polarity", pulse, 2'b00);

    // R5/R6 spacing in toggle mode: I=2 -> 8 ticks
    do_reset();
    iv = 2; mw = 255; tick_mode = 0;
    count_low(0, 2, 40, n);
    chk("R5 R6 spacing low span", n, 8);

    // R4 queue: first release one edge after arrival
    do_reset();
    iv = 3; mw = 255;
    @(negedge clk); req = 2'b01;
    @(negedge clk); req = 2'b00;
    chk("R4 not yet released", pulse, 2'b11);
    @(negedge clk);
    chk("R4 released next tick", pulse, 2'b10);

    // R7 width cap: I=2, mw=1 -> 6 ticks
    do_reset();
    iv = 2; mw = 1;
    count_low(0, 1, 40, n);
    chk("R7 capped width", n, 6);

    // R10 tick every other cycle -> 12 cycles
    do_reset();
    tick_mode = 1;
    count_low(0, 1, 60, n);
    chk("R10 width under tick gating", n, 12);
    tick_mode = 0;

    // R8 overflow on ch1
    do_reset();
    iv = 100; mw = 255;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); req = 2'b10;
    end
    @(negedge clk); req = 2'b00;
    chk("R8 R9 overflow ch1 only", ovf, 2'b10);
    repeat (3) @(negedge clk);
    chk("R8 overflow sticky", ovf, 2'b10);
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R8 overflow cleared", ovf, 2'b00);

    // random segments against model
    for (int s = 0; s < 14; s++) begin
      do_reset();
      case ($urandom % 5)
        0: iv = 0; 1: iv = 1; 2: iv = 2; 3: iv = 3; default: iv = 5;
      endcase
      case ($urandom % 4)
        0: mw = 0; 1: mw = 1; 2: mw = 2; default: mw = 255;
      endcase
      inv = $urandom % 2;
      tick_mode = $urandom % 3;
      for (int i = 0; i < 1200; i++) begin
        @(negedge clk);
        chk("R3 R4 R5 R6 R7 R8 R10 model pulse", pulse,
            {inv ? m_act[1] : !m_act[1], inv ? m_act[0] : !m_act[0]});
        chk("R8 model ovf", ovf, {m_ovf[1], m_ovf[0]});
        req[0] = ($urandom % ((s % 2) ? 3 : 9)) == 0;
        req[1] = ($urandom % 7) == 0;
        clr    = ($urandom % 60) == 0;
      end
    end
    req = '0; clr = 0;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20ns * 190000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule